// File: doc/BRIEF.md
# UART Diagnostic Loopback and Modem Line Control

This block sits between a UART's shift registers and its package pins. It routes the serial data stream and the four handshake lines. In normal operation the transmit bit goes to the serial output pin and the receiver takes the serial input pin. The modem control bits drive active-low output pins. The active-low modem input pins pass through a synchroniser and become the effective modem status.

A single mode input switches the block into a diagnostic self-test. In that mode the transmit bit feeds the receiver directly, and the control bits stand in for the modem inputs. Every external output stays idle, so nothing on the line or the handshake pins moves.

Sticky change flags record movement on the effective status lines. They include a flag for the trailing edge of the ring indicator. These flags feed the modem-status interrupt, which an enable input gates. A status-register read strobe clears them. Changing the mode never raises a flag.

Top module: `uart_lpbk_modem`

## Requirements
- R1: With `loop_en` low, `ser_out_pin` equals `tx_shift_out` and `rx_ser_in` equals `ser_in_pin`.
- R2: With `loop_en` high, `ser_out_pin` is 1, `rx_ser_in` equals `tx_shift_out`, and `ser_in_pin` has no effect.
- R3: Control bit order in `mctl_bits` is bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2. With `loop_en` low, `mdm_out_n` is the bitwise inverse of `mctl_bits`. With `loop_en` high, it is 4'b1111.
- R4: Status bit order in `mdm_status` and `mdm_in_n` is bit0 CTS, bit1 DSR, bit2 RI, bit3 DCD. The input pins are active low. With `loop_en` low, `mdm_status` is the inverse of `mdm_in_n` and reflects a pin change on the third rising clock edge after it (two synchroniser stages plus the status register).
- R5: With `loop_en` high, `mdm_status` takes CTS from RTS, DSR from DTR, RI from OUT1 and DCD from OUT2 one clock edge after `mctl_bits`. `mdm_in_n` has no effect in this mode.
- R6: `mdm_delta` uses the same bit order as the status. Bits 0, 1 and 3 set when the matching status bit changes in either direction. Bit 2 sets only when RI goes from 1 to 0. A flag sets on the same edge as the status update and stays set until cleared.
- R7: A cycle with `msr_read` high clears `mdm_delta` at the next edge. A flag whose event occurs on that same edge is set instead.
- R8: On the edge where `loop_en` takes a new value, no delta flag sets. This holds even though the status jumps between the pin view and the control-bit view.
- R9: `msi_irq` is high exactly when `msi_en` is high and at least one `mdm_delta` bit is set.
- R10: After reset, `mdm_status` and `mdm_delta` are 0 and the mode is treated as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | Diagnostic loopback mode |
| mctl_bits | input | 4 | Modem control bits: DTR, RTS, OUT1, OUT2 |
| tx_shift_out | input | 1 | Transmit shift register output bit |
| ser_in_pin | input | 1 | External serial input pin |
| mdm_in_n | input | 4 | External active-low modem inputs: CTS, DSR, RI, DCD |
| msi_en | input | 1 | Modem-status interrupt enable |
| msr_read | input | 1 | Modem status read strobe, clears the change flags |
| ser_out_pin | output | 1 | External serial output pin |
| rx_ser_in | output | 1 | Serial bit delivered to the receiver |
| mdm_out_n | output | 4 | External active-low modem output pins |
| mdm_status | output | 4 | Effective modem status: CTS, DSR, RI, DCD |
| mdm_delta | output | 4 | Sticky change flags: dCTS, dDSR, RI trailing, dDCD |
| msi_irq | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that `loop_en` and `mctl_bits` are synchronous to `clk`. They also assume `msr_read` is a single-cycle strobe from the register decode. The modem pins alone may change at any time. The bench drives every input one time unit after a falling edge, so each value is stable before the next rising edge. It holds the modem pins idle high through reset, so no flag is pending when checking begins. Each flag is cleared before a mode switch, so a suppressed event shows up as an unchanged zero.

// File: rtl/uart_lpbk_pkg.sv
package uart_lpbk_pkg;
  localparam int MDM_W = 4;

  // control bit positions
  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;

  // status bit positions
  localparam int ST_CTS = 0;
  localparam int ST_DSR = 1;
  localparam int ST_RI  = 2;
  localparam int ST_DCD = 3;

  typedef logic [MDM_W-1:0] mdm_vec_t;

  // self-test routing of control bits onto status lines
  function automatic mdm_vec_t loop_map(mdm_vec_t ctl);
    mdm_vec_t s;
    s[ST_CTS] = ctl[CTL_RTS];
    s[ST_DSR] = ctl[CTL_DTR];
    s[ST_RI]  = ctl[CTL_OUT1];
    s[ST_DCD] = ctl[CTL_OUT2];
    return s;
  endfunction

  // change events between two status samples; RI reports only its falling edge
  function automatic mdm_vec_t change_events(mdm_vec_t prev, mdm_vec_t nxt);
    mdm_vec_t e;
    e = prev ^ nxt;
    e[ST_RI] = prev[ST_RI] & ~nxt[ST_RI];
    return e;
  endfunction
endpackage

// File: rtl/uart_lpbk_sync.sv
module uart_lpbk_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/uart_lpbk_path.sv
module uart_lpbk_path
  import uart_lpbk_pkg::*;
(
  input  logic     loop_en,
  input  logic     tx_bit,
  input  logic     ser_in_pin,
  input  mdm_vec_t ctl,
  input  mdm_vec_t pins_sync_n,
  output logic     ser_out_pin,
  output logic     rx_bit,
  output mdm_vec_t pins_out_n,
  output mdm_vec_t stat_sel
);
  always_comb begin
    if (loop_en) begin
      ser_out_pin = 1'b1;
      rx_bit      = tx_bit;
      pins_out_n  = '1;
      stat_sel    = loop_map(ctl);
    end else begin
      ser_out_pin = tx_bit;
      rx_bit      = ser_in_pin;
      pins_out_n  = ~ctl;
      stat_sel    = ~pins_sync_n;
    end
  end
endmodule

// File: rtl/uart_lpbk_delta.sv
module uart_lpbk_delta
  import uart_lpbk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     loop_en,
  input  logic     msr_read,
  input  mdm_vec_t stat_sel,
  output mdm_vec_t stat_q,
  output mdm_vec_t delta_q,
  output logic     loop_change,
  output mdm_vec_t evt_vec
);
  logic     loop_q;
  mdm_vec_t delta_d;

  assign loop_change = loop_en ^ loop_q;
  assign evt_vec     = loop_change ? '0 : change_events(stat_q, stat_sel);
  assign delta_d     = (msr_read ? '0 : delta_q) | evt_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q  <= 1'b0;
      stat_q  <= '0;
      delta_q <= '0;
    end else begin
      loop_q  <= loop_en;
      stat_q  <= stat_sel;
      delta_q <= delta_d;
    end
  end
endmodule

// File: rtl/uart_lpbk_modem.sv
module uart_lpbk_modem
  import uart_lpbk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loop_en,
  input  logic [3:0] mctl_bits,
  input  logic       tx_shift_out,
  input  logic       ser_in_pin,
  input  logic [3:0] mdm_in_n,
  input  logic       msi_en,
  input  logic       msr_read,
  output logic       ser_out_pin,
  output logic       rx_ser_in,
  output logic [3:0] mdm_out_n,
  output logic [3:0] mdm_status,
  output logic [3:0] mdm_delta,
  output logic       msi_irq
);
  mdm_vec_t pins_sync_n;
  mdm_vec_t stat_sel;
  mdm_vec_t evt_vec;
  logic     loop_change;

  uart_lpbk_sync #(.W(MDM_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (mdm_in_n),
    .dout  (pins_sync_n)
  );

  uart_lpbk_path u_path (
    .loop_en     (loop_en),
    .tx_bit      (tx_shift_out),
    .ser_in_pin  (ser_in_pin),
    .ctl         (mctl_bits),
    .pins_sync_n (pins_sync_n),
    .ser_out_pin (ser_out_pin),
    .rx_bit      (rx_ser_in),
    .pins_out_n  (mdm_out_n),
    .stat_sel    (stat_sel)
  );

  uart_lpbk_delta u_delta (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_en     (loop_en),
    .msr_read    (msr_read),
    .stat_sel    (stat_sel),
    .stat_q      (mdm_status),
    .delta_q     (mdm_delta),
    .loop_change (loop_change),
    .evt_vec     (evt_vec)
  );

  assign msi_irq = msi_en & (|mdm_delta);
endmodule

// File: rtl/uart_lpbk_modem_chk.sv
module uart_lpbk_modem_chk
  import uart_lpbk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       loop_en,
  input logic [3:0] mctl_bits,
  input logic       tx_shift_out,
  input logic       ser_in_pin,
  input logic       msr_read,
  input logic       ser_out_pin,
  input logic       rx_ser_in,
  input logic [3:0] mdm_out_n,
  input logic [3:0] mdm_status,
  input logic [3:0] mdm_delta,
  input logic       msi_irq,
  input logic       loop_change,
  input logic [3:0] evt_vec
);
  assert_norm_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |-> (ser_out_pin == tx_shift_out && rx_ser_in == ser_in_pin));

  assert_loop_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (ser_out_pin && rx_ser_in == tx_shift_out));

  assert_pins_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> (mdm_out_n == 4'hF));

  assert_loop_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> (mdm_status == loop_map($past(mctl_bits))));

  assert_ri_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdm_delta[ST_RI] && !mdm_status[ST_RI] && !msr_read) |=> !mdm_delta[ST_RI]);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_read && evt_vec == 4'h0) |=> (mdm_delta == 4'h0));

  assert_switch_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_change && mdm_delta == 4'h0) |=> (mdm_delta == 4'h0));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mdm_delta == 4'h0) |-> !msi_irq);
endmodule

bind uart_lpbk_modem uart_lpbk_modem_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .loop_en      (loop_en),
  .mctl_bits    (mctl_bits),
  .tx_shift_out (tx_shift_out),
  .ser_in_pin   (ser_in_pin),
  .msr_read     (msr_read),
  .ser_out_pin  (ser_out_pin),
  .rx_ser_in    (rx_ser_in),
  .mdm_out_n    (mdm_out_n),
  .mdm_status   (mdm_status),
  .mdm_delta    (mdm_delta),
  .msi_irq      (msi_irq),
  .loop_change  (loop_change),
  .evt_vec      (evt_vec)
);

// File: tb/tb_uart_lpbk_modem.sv
`timescale 1ns/1ps
module tb_uart_lpbk_modem;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       loop_en = 1'b0;
  logic [3:0] mctl_bits = 4'h0;
  logic       tx_shift_out = 1'b1;
  logic       ser_in_pin = 1'b1;
  logic [3:0] mdm_in_n = 4'hF;
  logic       msi_en = 1'b1;
  logic       msr_read = 1'b0;
  logic       ser_out_pin, rx_ser_in, msi_irq;
  logic [3:0] mdm_out_n, mdm_status, mdm_delta;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [14:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  uart_lpbk_modem dut (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .mctl_bits(mctl_bits),
    .tx_shift_out(tx_shift_out), .ser_in_pin(ser_in_pin), .mdm_in_n(mdm_in_n),
    .msi_en(msi_en), .msr_read(msr_read), .ser_out_pin(ser_out_pin),
    .rx_ser_in(rx_ser_in), .mdm_out_n(mdm_out_n), .mdm_status(mdm_status),
    .mdm_delta(mdm_delta), .msi_irq(msi_irq)
  );

  // expected self-test status: CTS<-RTS, DSR<-DTR, RI<-OUT1, DCD<-OUT2
  function automatic logic [3:0] bench_loop_status(logic [3:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  // builds the full expected output vector from the currently driven inputs
  function automatic logic [14:0] expect_vec(logic [3:0] st, logic [3:0] dl);
    logic so, rx, irq;
    logic [3:0] on;
    so  = loop_en ? 1'b1 : tx_shift_out;
    rx  = loop_en ? tx_shift_out : ser_in_pin;
    on  = loop_en ? 4'b1111 : {~mctl_bits[3], ~mctl_bits[2], ~mctl_bits[1], ~mctl_bits[0]};
    irq = msi_en && (dl != 4'h0);
    return {so, rx, on, st, dl, irq};
  endfunction

  task automatic step_in();
    @(negedge clk);
    #1;
  endtask

  // driver side: wait n rising edges, then queue the expectation
  task automatic expect_after(int n, logic [3:0] st, logic [3:0] dl, string tag);
    repeat (n) @(posedge clk);
    exp_q.push_back(expect_vec(st, dl));
    tag_q.push_back(tag);
  endtask

  task automatic read_status(logic [3:0] st, logic [3:0] dl, string tag);
    step_in();
    msr_read = 1'b1;
    expect_after(1, st, dl, tag);
    step_in();
    msr_read = 1'b0;
  endtask

  // monitor: compare queued expectations away from the rising edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [14:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {ser_out_pin, rx_ser_in, mdm_out_n, mdm_status, mdm_delta, msi_irq};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: actual so=%b rx=%b on=%b st=%b dl=%b irq=%b expected so=%b rx=%b on=%b st=%b dl=%b irq=%b",
                 t, a[14], a[13], a[12:9], a[8:5], a[4:1], a[0],
                 e[14], e[13], e[12:9], e[8:5], e[4:1], e[0]);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    expect_after(1, 4'b0000, 4'b0000, "R10 reset state");

    step_in(); tx_shift_out = 1'b0; ser_in_pin = 1'b0;
    expect_after(1, 4'b0000, 4'b0000, "R1 normal data path");

    step_in(); mctl_bits = 4'b0101;
    expect_after(1, 4'b0000, 4'b0000, "R3 inverted control pins");

    step_in(); mdm_in_n = 4'b1110;
    expect_after(2, 4'b0000, 4'b0000, "R4 status not before third edge");
    expect_after(1, 4'b0001, 4'b0001, "R4/R6 CTS asserted and flagged");

    read_status(4'b0001, 4'b0000, "R7 read clears flags");

    step_in(); mdm_in_n = 4'b1010;
    expect_after(3, 4'b0101, 4'b0000, "R6 RI leading edge not flagged");

    step_in(); mdm_in_n = 4'b1110;
    expect_after(3, 4'b0001, 4'b0100, "R6 RI trailing edge flagged");

    step_in(); msi_en = 1'b0;
    expect_after(1, 4'b0001, 4'b0100, "R9 interrupt gated off");
    step_in(); msi_en = 1'b1;
    expect_after(1, 4'b0001, 4'b0100, "R9 interrupt with enable");

    read_status(4'b0001, 4'b0000, "R7 clear after RI");

    step_in(); mdm_in_n = 4'b0100;
    expect_after(3, 4'b1011, 4'b1010, "R6 DSR and DCD changes flagged");
    read_status(4'b1011, 4'b0000, "R7 clear before mode switch");

    step_in(); loop_en = 1'b1; ser_in_pin = 1'b1;
    expect_after(1, bench_loop_status(4'b0101), 4'b0000, "R8/R2 enter self-test quietly");

    step_in(); tx_shift_out = 1'b1;
    expect_after(1, bench_loop_status(4'b0101), 4'b0000, "R2 receiver follows transmit bit");

    step_in(); mdm_in_n = 4'b1111;
    expect_after(4, bench_loop_status(4'b0101), 4'b0000, "R5 external pins ignored");

    step_in(); mctl_bits = 4'b1010;
    expect_after(1, 4'b1001, 4'b1111, "R5/R6 control bits drive status");

    step_in(); msr_read = 1'b1; mctl_bits = 4'b1000;
    expect_after(1, 4'b1000, 4'b0001, "R7 event wins over read clear");
    step_in(); msr_read = 1'b0;

    read_status(4'b1000, 4'b0000, "R7 clear in self-test");

    step_in(); loop_en = 1'b0;
    expect_after(1, 4'b0000, 4'b0000, "R8 leave self-test quietly");
    expect_after(1, 4'b0000, 4'b0000, "R8 no late flag");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule